// File: doc/BRIEF.md
# Root-Port Interrupt Aggregator

This block collects the interrupt sources of a PCIe root-port bridge into one 32-bit status word. It drives a single level-sensitive summary line toward the system interrupt controller. Six event sources arrive as one-cycle pulses and are held in sticky status bits until software clears them. These are completion timeout, power-management event received, PME turn-off acknowledge received, and correctable, non-fatal and fatal error messages. The four legacy INTx wires are level inputs whose status bits track the wires.

Software sees four 32-bit words through a plain write-strobe and combinational-read port. The first is a status word, where writing ones clears event bits. The second is a read-only mask view. The other two are write-only strobes, one that unmasks the bits written as one and one that masks them. A handler reads status and mask, services status AND NOT mask, and writes the serviced bits back to status.

Top module: `rp_irq_aggregator`

## Requirements
- R1: Status is at offset 0x4C0, mask view at 0x4C4, unmask strobe at 0x4C8 and mask strobe at 0x4CC. Any other offset reads 0, and a write to it changes nothing.
- R2: After reset every status bit is 0, the mask reads 0x1F558000 (every implemented source masked), and irq_out is low.
- R3: A write to 0x4C8 clears the mask bits written as 1 and leaves bits written as 0 unchanged. The new mask is readable in the cycle after the write.
- R4: A write to 0x4CC sets the mask bits written as 1 and leaves bits written as 0 unchanged.
- R5: Event pulses set status bits as follows: evt_pulse[0] at bit 15, [1] at bit 24, [2] at bit 25, [3] at bit 26, [4] at bit 27 and [5] at bit 28. Each bit is readable one cycle after its pulse and stays set until cleared.
- R6: Writing 1 to an event bit at 0x4C0 clears it. Bits written as 0 are unchanged.
- R7: When a pulse and a clearing write hit the same event bit in the same cycle, the bit ends up set.
- R8: INTx line n (0..3) reports at status bit 16+2n, that is bits 16, 18, 20 and 22. The bit follows the wire level one cycle later. A clearing write to it has no lasting effect.
- R9: The undefined bit positions (all except 15, 16, 18, 20, 22 and 24..28) read 0 in status and mask, and writes to them are ignored. The unmask and mask strobe words read 0.
- R10: irq_out is high exactly when some status bit is set whose mask bit is 0. It follows status and mask with no extra register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| evt_pulse | input | 6 | One-cycle event pulses, order given in R5 |
| intx_level | input | 4 | Legacy INTx wire levels, line 0 to 3 |
| wr_en | input | 1 | Register write strobe |
| addr | input | 12 | Register byte offset, used for both read and write |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for addr, combinational |
| irq_out | output | 1 | Level summary interrupt |

## Verification
Every register update appears one clock edge after the cycle that causes it. This covers event pulses, INTx levels, clearing writes and both mask strobes. rdata and irq_out follow the registered state combinationally, with no further delay. The bench therefore drives each stimulus at a falling edge, lets one rising edge pass and compares at the next falling edge. It uses a model that has advanced by exactly that one edge. Reads settle the address a nanosecond before sampling rdata, so a read never crosses a clock edge.

// File: rtl/rp_irq_pkg.sv
// Package: bit positions and shared types of the root-port interrupt aggregator.
// Assumes a 32-bit register word; event and INTx positions are fixed by software.
package rp_irq_pkg;

    localparam int REG_W     = 32;
    localparam int EVT_N     = 6;
    localparam int INTX_N    = 4;
    localparam int INTX_LSB  = 16;
    localparam int INTX_STEP = 2;

    // Status bit position of event source idx.
    function automatic int evt_bit(input int idx);
        case (idx)
            0:       return 15;
            1:       return 24;
            2:       return 25;
            3:       return 26;
            4:       return 27;
            default: return 28;
        endcase
    endfunction

    // Status bit position of INTx line n.
    function automatic int intx_bit(input int n);
        return INTX_LSB + INTX_STEP * n;
    endfunction

    // All event positions as a word.
    function automatic logic [REG_W-1:0] evt_field();
        logic [REG_W-1:0] f;
        f = '0;
        for (int i = 0; i < EVT_N; i++) f[evt_bit(i)] = 1'b1;
        return f;
    endfunction

    // All INTx positions as a word.
    function automatic logic [REG_W-1:0] intx_field();
        logic [REG_W-1:0] f;
        f = '0;
        for (int n = 0; n < INTX_N; n++) f[intx_bit(n)] = 1'b1;
        return f;
    endfunction

    localparam logic [REG_W-1:0] IMPL_BITS = evt_field() | intx_field();

    // Decoded write strobes, at most one high per cycle.
    typedef struct packed {
        logic clr;       // write-one-to-clear on status
        logic unmask;    // write-one-to-unmask
        logic mask_set;  // write-one-to-mask
    } wr_strobe_t;

endpackage

// File: rtl/rp_irq_regif.sv
// Register interface: decodes the offset into write strobes and muxes read data.
// Assumes one access per cycle; purely combinational.
module rp_irq_regif
    import rp_irq_pkg::*;
#(
    parameter int              ADDR_W     = 12,
    parameter logic [ADDR_W-1:0] OFS_STATUS = 12'h4C0,
    parameter logic [ADDR_W-1:0] OFS_MASK   = 12'h4C4,
    parameter logic [ADDR_W-1:0] OFS_UNMASK = 12'h4C8,
    parameter logic [ADDR_W-1:0] OFS_MSET   = 12'h4CC
) (
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [REG_W-1:0]  wdata,
    input  logic [REG_W-1:0]  status,
    input  logic [REG_W-1:0]  mask,
    output wr_strobe_t        stb,
    output logic [REG_W-1:0]  wr_bits,
    output logic [REG_W-1:0]  rdata
);

    // Write strobes from the offset; only implemented bits pass.
    always_comb begin
        stb.clr      = wr_en && (addr == OFS_STATUS);
        stb.unmask   = wr_en && (addr == OFS_UNMASK);
        stb.mask_set = wr_en && (addr == OFS_MSET);
        wr_bits      = wdata & IMPL_BITS;
    end

    // Read mux; strobe words and unmapped offsets return zero.
    always_comb begin
        if (addr == OFS_STATUS)    rdata = status;
        else if (addr == OFS_MASK) rdata = mask;
        else                       rdata = '0;
    end

endmodule

// File: rtl/rp_irq_status.sv
// Status word: sticky event bits set by pulses and cleared by software,
// plus INTx bits that track their wires one cycle late.
// Assumes pulses are one cycle wide and already synchronous to clk.
module rp_irq_status
    import rp_irq_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [EVT_N-1:0]  evt_pulse,
    input  logic [INTX_N-1:0] intx_level,
    input  logic              clr_en,
    input  logic [REG_W-1:0]  clr_bits,
    output logic [REG_W-1:0]  status
);

    logic [EVT_N-1:0]  evt_q;
    logic [INTX_N-1:0] intx_q;

    for (genvar i = 0; i < EVT_N; i++) begin : g_evt
        localparam int POS = evt_bit(i);

        // Sticky event bit: a new pulse takes priority over a clearing write.
        always_ff @(posedge clk) begin
            if (!rst_n)                         evt_q[i] <= 1'b0;
            else if (evt_pulse[i])              evt_q[i] <= 1'b1;
            else if (clr_en && clr_bits[POS])   evt_q[i] <= 1'b0;
        end

        assert_set_wins_R7: assert property (@(posedge clk) disable iff (!rst_n)
            evt_pulse[i] |=> status[POS]);

        assert_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
            status[POS] && !(clr_en && clr_bits[POS]) |=> status[POS]);
    end

    for (genvar n = 0; n < INTX_N; n++) begin : g_intx
        localparam int POS = intx_bit(n);

        // INTx status bit registers the wire level each cycle.
        always_ff @(posedge clk) begin
            if (!rst_n) intx_q[n] <= 1'b0;
            else        intx_q[n] <= intx_level[n];
        end

        assert_intx_follow_R8: assert property (@(posedge clk) disable iff (!rst_n)
            1'b1 |=> status[POS] == $past(intx_level[n]));
    end

    // Places event and INTx bits at their positions; others stay zero.
    always_comb begin
        status = '0;
        for (int i = 0; i < EVT_N; i++)  status[evt_bit(i)]  = evt_q[i];
        for (int n = 0; n < INTX_N; n++) status[intx_bit(n)] = intx_q[n];
    end

endmodule

// File: rtl/rp_irq_mask.sv
// Mask word: a 1 masks the source. Changed only by set and clear strobes.
// Assumes incoming bits are already limited to implemented positions.
module rp_irq_mask
    import rp_irq_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             unmask,
    input  logic             mask_set,
    input  logic [REG_W-1:0] bits,
    output logic [REG_W-1:0] mask
);

    logic [REG_W-1:0] mask_q;

    // Mask update: reset masks everything, strobes touch only bits written as 1.
    always_ff @(posedge clk) begin
        if (!rst_n)        mask_q <= IMPL_BITS;
        else if (unmask)   mask_q <= mask_q & ~bits;
        else if (mask_set) mask_q <= mask_q | bits;
    end

    assign mask = mask_q;

    assert_unmask_R3: assert property (@(posedge clk) disable iff (!rst_n)
        unmask |=> (mask & $past(bits)) == '0);

    assert_mask_set_R4: assert property (@(posedge clk) disable iff (!rst_n)
        mask_set && !unmask |=> (mask & $past(bits)) == $past(bits));

    assert_mask_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !unmask && !mask_set |=> $stable(mask));

endmodule

// File: rtl/rp_irq_aggregator.sv
// Top: root-port interrupt aggregator. Ties register interface, status word and
// mask word together and drives the level summary interrupt.
// Assumes synchronous inputs and a single-cycle register access.
module rp_irq_aggregator
    import rp_irq_pkg::*;
#(
    parameter int                ADDR_W     = 12,
    parameter logic [ADDR_W-1:0] OFS_STATUS = 12'h4C0,
    parameter logic [ADDR_W-1:0] OFS_MASK   = 12'h4C4,
    parameter logic [ADDR_W-1:0] OFS_UNMASK = 12'h4C8,
    parameter logic [ADDR_W-1:0] OFS_MSET   = 12'h4CC
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [5:0]        evt_pulse,
    input  logic [3:0]        intx_level,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [31:0]       wdata,
    output logic [31:0]       rdata,
    output logic              irq_out
);

    wr_strobe_t       stb;
    logic [REG_W-1:0] wr_bits;
    logic [REG_W-1:0] status;
    logic [REG_W-1:0] mask;

    rp_irq_regif #(
        .ADDR_W(ADDR_W), .OFS_STATUS(OFS_STATUS), .OFS_MASK(OFS_MASK),
        .OFS_UNMASK(OFS_UNMASK), .OFS_MSET(OFS_MSET)
    ) u_regif (
        .wr_en(wr_en), .addr(addr), .wdata(wdata), .status(status), .mask(mask),
        .stb(stb), .wr_bits(wr_bits), .rdata(rdata)
    );

    rp_irq_status u_status (
        .clk(clk), .rst_n(rst_n), .evt_pulse(evt_pulse), .intx_level(intx_level),
        .clr_en(stb.clr), .clr_bits(wr_bits), .status(status)
    );

    rp_irq_mask u_mask (
        .clk(clk), .rst_n(rst_n), .unmask(stb.unmask), .mask_set(stb.mask_set),
        .bits(wr_bits), .mask(mask)
    );

    // Summary line: any pending source that is not masked.
    always_comb irq_out = |(status & ~mask);

    assert_irq_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (mask == IMPL_BITS) |-> !irq_out);

    assert_rd_unmapped_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (addr != OFS_STATUS) && (addr != OFS_MASK) |-> rdata == '0);

endmodule

// File: tb/rp_irq_aggregator_bench.sv
`timescale 1ns/1ps
module rp_irq_aggregator_bench;

    localparam logic [11:0] A_STAT = 12'h4C0;
    localparam logic [11:0] A_MASK = 12'h4C4;
    localparam logic [11:0] A_UNM  = 12'h4C8;
    localparam logic [11:0] A_MSET = 12'h4CC;
    localparam logic [31:0] IMPL   = 32'h1F55_8000;
    localparam logic [31:0] EVTS   = 32'h1F00_8000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [5:0]  evt_pulse = '0;
    logic [3:0]  intx_level = '0;
    logic        wr_en = 1'b0;
    logic [11:0] addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        irq_out;

    int checks = 0;
    int errors = 0;

    logic [31:0] m_evt  = '0;
    logic [31:0] m_intx = '0;
    logic [31:0] m_mask = IMPL;

    always #2.5 clk = ~clk;

    rp_irq_aggregator u_rp_irq_aggregator (
        .clk(clk), .rst_n(rst_n), .evt_pulse(evt_pulse), .intx_level(intx_level),
        .wr_en(wr_en), .addr(addr), .wdata(wdata), .rdata(rdata), .irq_out(irq_out)
    );

    function automatic logic [31:0] evt_word(input logic [5:0] p);
        logic [31:0] w = '0;
        w[15] = p[0]; w[24] = p[1]; w[25] = p[2];
        w[26] = p[3]; w[27] = p[4]; w[28] = p[5];
        return w;
    endfunction

    function automatic logic [31:0] intx_word(input logic [3:0] l);
        logic [31:0] w = '0;
        for (int n = 0; n < 4; n++) w[16 + 2*n] = l[n];
        return w;
    endfunction

    function automatic logic [31:0] exp_read(input logic [11:0] a);
        if (a == A_STAT) return m_evt | m_intx;
        if (a == A_MASK) return m_mask;
        return 32'h0;
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h", req, act, exp);
        end
    endtask

    // One clock: model advances by the same edge the design sees.
    task automatic tick();
        logic [31:0] n_evt, n_mask, wb;
        wb     = wdata & IMPL;
        n_evt  = m_evt;
        n_mask = m_mask;
        if (wr_en && addr == A_STAT) n_evt = n_evt & ~(wb & EVTS);
        n_evt = n_evt | evt_word(evt_pulse);
        if (wr_en && addr == A_UNM)  n_mask = n_mask & ~wb;
        if (wr_en && addr == A_MSET) n_mask = n_mask | wb;
        @(posedge clk);
        @(negedge clk);
        m_evt  = n_evt;
        m_mask = n_mask;
        m_intx = intx_word(intx_level);
        wr_en = 1'b0;
        evt_pulse = '0;
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        addr = a; wdata = d; wr_en = 1'b1;
        tick();
    endtask

    task automatic rd_chk(input string req, input logic [11:0] a);
        addr = a;
        #1;
        chk(req, rdata, exp_read(a));
    endtask

    task automatic irq_chk(input string req);
        chk(req, {31'b0, irq_out}, {31'b0, |((m_evt | m_intx) & ~m_mask)});
    endtask

    initial begin
        #1_000_000;
        errors++;
        checks++;
        $display("FAIL watchdog actual timeout expected completion");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [31:0] seed;
        logic [11:0] alist [6];
        seed = 32'h0000_5EED;
        void'($urandom(seed));
        alist[0] = A_STAT; alist[1] = A_MASK; alist[2] = A_UNM;
        alist[3] = A_MSET; alist[4] = 12'h4D0; alist[5] = 12'h000;

        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        // R2 reset state
        rd_chk("R2 status", A_STAT);
        chk("R2 mask", rdata, 32'h0);
        rd_chk("R2 mask", A_MASK);
        chk("R2 mask value", rdata, 32'h1F55_8000);
        irq_chk("R2 irq");
        rd_chk("R9 unmask word reads 0", A_UNM);
        rd_chk("R9 mask-set word reads 0", A_MSET);

        // R5 each event position, one at a time
        for (int i = 0; i < 6; i++) begin
            evt_pulse = 6'(1 << i);
            tick();
            rd_chk("R5 event position", A_STAT);
            irq_chk("R10 masked event no irq");
        end
        tick();
        rd_chk("R5 sticky after idle", A_STAT);

        // R3 zero write no effect, then unmask bit 15
        wr(A_UNM, 32'h0);
        rd_chk("R3 zero write", A_MASK);
        wr(A_UNM, 32'h0000_8000);
        rd_chk("R3 unmask bit15", A_MASK);
        irq_chk("R10 irq after unmask");
        chk("R10 irq high", {31'b0, irq_out}, 32'h1);
        // R4 mask again
        wr(A_MSET, 32'h0000_8000);
        rd_chk("R4 mask bit15", A_MASK);
        irq_chk("R4 irq low after mask");
        // R6 clear: zero write then real clear
        wr(A_STAT, 32'h0);
        rd_chk("R6 zero clear", A_STAT);
        wr(A_STAT, 32'h0100_8000);
        rd_chk("R6 clear bits 15,24", A_STAT);
        // R7 set wins
        evt_pulse = 6'b000100;
        addr = A_STAT; wdata = 32'h0200_0000; wr_en = 1'b1;
        tick();
        rd_chk("R7 set wins", A_STAT);
        chk("R7 bit25", {31'b0, rdata[25]}, 32'h1);
        // R8 INTx line 1 at bit 18
        intx_level = 4'b0010;
        tick();
        rd_chk("R8 intx bit18", A_STAT);
        chk("R8 bit18 set", {31'b0, rdata[18]}, 32'h1);
        wr(A_STAT, 32'h0004_0000);
        rd_chk("R8 clear no lasting effect", A_STAT);
        intx_level = 4'b0000;
        tick();
        rd_chk("R8 follows wire low", A_STAT);
        // R9 undefined bits
        wr(A_UNM, 32'hFFFF_FFFF);
        rd_chk("R9 unmask all", A_MASK);
        chk("R9 mask zero", rdata, 32'h0);
        wr(A_MSET, 32'hFFFF_FFFF);
        rd_chk("R9 mask only implemented", A_MASK);
        chk("R9 mask value", rdata, 32'h1F55_8000);
        // R1 unmapped write ignored
        wr(12'h4D0, 32'hFFFF_FFFF);
        rd_chk("R1 unmapped write", A_MASK);
        rd_chk("R1 unmapped read", 12'h4D0);

        // Random phase
        for (int k = 0; k < 400; k++) begin
            logic [31:0] r;
            r = $urandom();
            evt_pulse  = (r[3:0] == 4'h0) ? 6'($urandom()) : 6'h0;
            intx_level = (r[7:4] == 4'h0) ? 4'($urandom()) : intx_level;
            if (r[9:8] != 2'b00) begin
                addr  = alist[$urandom() % 6];
                wdata = $urandom();
                wr_en = 1'b1;
            end
            tick();
            rd_chk("R1 R3 R4 R5 R6 R8 random read", alist[$urandom() % 6]);
            irq_chk("R10 random irq");
        end

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule